// File: doc/BRIEF.md
# Dual-Bank Flash Address Remapper

This block sits between the flash access path and a flash array that is split into two equal physical banks, A and B. It turns a logical byte address into a physical bank select and a byte offset inside that bank, so that whichever bank currently holds the running program always appears at logical address zero. The lower half of the logical space maps to the active bank and the upper half maps to the other one. A single register holds a flag that says whether bank B is mapped first. The flag is loaded from an input during reset, which lets the surrounding logic restore a persisted choice.

The total flash size comes from a page count parameter multiplied by a page size parameter. Only the low 24 bits of an incoming address take part in decoding. Addresses that land beyond the flash size are flagged as out of range, and no bank is selected for them.

A swap request exchanges the two banks. The block holds the request until the flash reports that it is idle. It then flips the flag and raises a one-cycle processor reset request on the same clock edge. After that reset, the formerly inactive bank answers at address zero.

Top module: `flash_bank_remap`

## Requirements
- R1: During and right after a synchronous reset the "bank A first" status equals the inverse of `boot_b_first`, `core_rst_req` is low, and `map_valid` is low.
- R2: With bank A first, a lookup of an address below half the flash size gives `map_bank_sel` = 2'b01 (bit 0 is bank A) and an offset equal to the address.
- R3: With bank A first, a lookup at or above half the flash size and below the flash size gives `map_bank_sel` = 2'b10 (bit 1 is bank B) and an offset equal to the address minus half the flash size.
- R4: With bank B first, the two halves map to the opposite banks: the lower half goes to bank B and the upper half to bank A, with the same offsets as R2 and R3.
- R5: Address bits 31 to 24 are ignored. An address gives the same result as the same address with those bits cleared.
- R6: A masked address at or above the flash size (PAGE_COUNT x PAGE_BYTES) gives `map_oor` = 1, `map_bank_sel` = 2'b00 and offset 0. The last byte of the flash is not out of range.
- R7: A lookup presented in one cycle produces its result in the next cycle with `map_valid` = 1. In a cycle without a lookup request, `map_valid` and all result fields are 0.
- R8: While `flash_ready` is low, a pending swap neither changes the mapping nor raises `core_rst_req`.
- R9: A swap commits on an edge where it is pending or requested and `flash_ready` is high. The flag toggles and `core_rst_req` is high for exactly one cycle, both starting after that same edge.
- R10: A lookup presented in the cycle in which a swap commits uses the mapping from before the swap. The next lookup uses the new mapping.
- R11: Several swap requests made while waiting for `flash_ready` produce exactly one swap and one reset pulse.
- R12: `a_first` is 1 exactly when bank A is mapped at address zero, and it follows every swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_b_first | input | 1 | Flag value loaded during reset; 1 means bank B is mapped first |
| lookup_valid | input | 1 | Address lookup request |
| lookup_addr | input | 32 | Logical byte address; only bits 23:0 are decoded |
| flash_ready | input | 1 | High when no flash operation is in progress |
| swap_req | input | 1 | Request to exchange the banks and reset the processor |
| map_valid | output | 1 | Registered result is present |
| map_bank_sel | output | 2 | Physical bank select: bit 0 is bank A, bit 1 is bank B |
| map_offset | output | OFS_W | Byte offset inside the selected bank |
| map_oor | output | 1 | Address lies beyond the flash size |
| a_first | output | 1 | Bank A is mapped at address zero |
| core_rst_req | output | 1 | One-cycle processor reset request issued by a swap |

## Verification
Address translation and the swap commit can fall on the same clock edge. In that case the lookup must be decoded with the flag value from before the flip, while the flag and the reset pulse change together. The bench provokes this by driving a lookup of address zero in the same cycle as a swap request, with `flash_ready` already high. It then checks three things: the registered result names the old bank, `a_first` has flipped, and `core_rst_req` is high. A lookup in the following cycle must select the other bank.

// File: rtl/flash_remap_pkg.sv
package flash_remap_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'b00,
    SEL_A    = 2'b01,
    SEL_B    = 2'b10
  } bank_sel_e;

  function automatic bank_sel_e phys_sel(input logic upper_half, input logic b_first);
    return (upper_half ^ b_first) ? SEL_B : SEL_A;
  endfunction

endpackage

// File: rtl/flash_bank_flag.sv
module flash_bank_flag (
  input  logic clk,
  input  logic rst,
  input  logic boot_b_first,
  input  logic swap_req,
  input  logic flash_ready,
  output logic b_first,
  output logic core_rst_req
);

  logic pending_q;
  logic want_swap;
  logic commit;

  // a request during the reset pulse waits one cycle, so pulses never merge
  assign want_swap = pending_q | swap_req;
  assign commit    = want_swap & flash_ready & ~core_rst_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      b_first      <= boot_b_first;
      core_rst_req <= 1'b0;
      pending_q    <= 1'b0;
    end else begin
      core_rst_req <= commit;
      if (commit) begin
        b_first   <= ~b_first;
        pending_q <= 1'b0;
      end else if (swap_req) begin
        pending_q <= 1'b1;
      end
    end
  end

  assert_pulse_single_R9: assert property (@(posedge clk) disable iff (rst)
    core_rst_req |=> !core_rst_req);

  assert_flip_has_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    (b_first != $past(b_first)) |-> core_rst_req);

  assert_pulse_has_flip_R12: assert property (@(posedge clk) disable iff (rst)
    core_rst_req |-> (b_first != $past(b_first)));

  assert_pulse_after_ready_R8: assert property (@(posedge clk) disable iff (rst)
    core_rst_req |-> $past(flash_ready));

endmodule

// File: rtl/flash_addr_xlate.sv
module flash_addr_xlate #(
  parameter int ADDR_W      = 32,
  parameter int KEEP_W      = 24,
  parameter int FLASH_BYTES = 524288,
  parameter int OFS_W       = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              b_first,
  input  logic              lookup_valid,
  input  logic [ADDR_W-1:0] lookup_addr,
  output logic              map_valid,
  output logic [1:0]        map_sel,
  output logic [OFS_W-1:0]  map_offset,
  output logic              map_oor
);
  import flash_remap_pkg::*;

  localparam int CMP_W = KEEP_W + 1;
  localparam logic [CMP_W-1:0] FLASH_L = CMP_W'(FLASH_BYTES);

  logic [CMP_W-1:0] masked;
  logic             oor;
  logic             upper;
  bank_sel_e        sel_d;

  assign masked = {1'b0, lookup_addr[KEEP_W-1:0]};
  assign oor    = (masked >= FLASH_L);
  assign upper  = masked[OFS_W];
  assign sel_d  = oor ? SEL_NONE : phys_sel(upper, b_first);

  always_ff @(posedge clk) begin
    if (rst) begin
      map_valid  <= 1'b0;
      map_sel    <= SEL_NONE;
      map_offset <= '0;
      map_oor    <= 1'b0;
    end else if (lookup_valid) begin
      map_valid  <= 1'b1;
      map_sel    <= sel_d;
      map_offset <= oor ? '0 : masked[OFS_W-1:0];
      map_oor    <= oor;
    end else begin
      map_valid  <= 1'b0;
      map_sel    <= SEL_NONE;
      map_offset <= '0;
      map_oor    <= 1'b0;
    end
  end

  assert_oor_no_sel_R6: assert property (@(posedge clk) disable iff (rst)
    map_oor |-> (map_sel == 2'b00 && map_offset == '0));

  assert_sel_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(map_sel));

  assert_valid_follows_R7: assert property (@(posedge clk) disable iff (rst)
    map_valid |-> $past(lookup_valid));

  assert_inrange_selects_R3: assert property (@(posedge clk) disable iff (rst)
    (map_valid && !map_oor) |-> ($countones(map_sel) == 1));

endmodule

// File: rtl/flash_bank_remap.sv
module flash_bank_remap #(
  parameter int PAGE_COUNT = 1024,
  parameter int PAGE_BYTES = 512,
  parameter int ADDR_W     = 32,
  parameter int KEEP_W     = 24,
  localparam int FLASH_BYTES = PAGE_COUNT * PAGE_BYTES,
  localparam int BANK_BYTES  = FLASH_BYTES / 2,
  localparam int OFS_W       = $clog2(BANK_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              boot_b_first,
  input  logic              lookup_valid,
  input  logic [ADDR_W-1:0] lookup_addr,
  input  logic              flash_ready,
  input  logic              swap_req,
  output logic              map_valid,
  output logic [1:0]        map_bank_sel,
  output logic [OFS_W-1:0]  map_offset,
  output logic              map_oor,
  output logic              a_first,
  output logic              core_rst_req
);

  logic b_first;

  flash_bank_flag u_flag (
    .clk          (clk),
    .rst          (rst),
    .boot_b_first (boot_b_first),
    .swap_req     (swap_req),
    .flash_ready  (flash_ready),
    .b_first      (b_first),
    .core_rst_req (core_rst_req)
  );

  flash_addr_xlate #(
    .ADDR_W      (ADDR_W),
    .KEEP_W      (KEEP_W),
    .FLASH_BYTES (FLASH_BYTES),
    .OFS_W       (OFS_W)
  ) u_xlate (
    .clk          (clk),
    .rst          (rst),
    .b_first      (b_first),
    .lookup_valid (lookup_valid),
    .lookup_addr  (lookup_addr),
    .map_valid    (map_valid),
    .map_sel      (map_bank_sel),
    .map_offset   (map_offset),
    .map_oor      (map_oor)
  );

  assign a_first = ~b_first;

  assert_size_fits_R5: assert property (@(posedge clk)
    (FLASH_BYTES <= (1 << KEEP_W)) && (BANK_BYTES == (1 << OFS_W)));

endmodule

// File: tb/flash_bank_remap_tb.sv
module flash_bank_remap_tb;

  localparam int PAGE_COUNT = 1024;
  localparam int PAGE_BYTES = 512;
  localparam int FLASH = PAGE_COUNT * PAGE_BYTES;
  localparam int BANK  = FLASH / 2;
  localparam int OFS_W = $clog2(BANK);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic boot_b_first = 1'b0;
  logic lookup_valid = 1'b0;
  logic [31:0] lookup_addr = '0;
  logic flash_ready = 1'b1;
  logic swap_req = 1'b0;
  logic map_valid;
  logic [1:0] map_bank_sel;
  logic [OFS_W-1:0] map_offset;
  logic map_oor;
  logic a_first;
  logic core_rst_req;

  int checks = 0;
  int fails = 0;
  logic model_b_first = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  flash_bank_remap #(.PAGE_COUNT(PAGE_COUNT), .PAGE_BYTES(PAGE_BYTES)) u_dut (
    .clk(clk), .rst(rst), .boot_b_first(boot_b_first),
    .lookup_valid(lookup_valid), .lookup_addr(lookup_addr),
    .flash_ready(flash_ready), .swap_req(swap_req),
    .map_valid(map_valid), .map_bank_sel(map_bank_sel), .map_offset(map_offset),
    .map_oor(map_oor), .a_first(a_first), .core_rst_req(core_rst_req)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic bf);
    @(negedge clk);
    boot_b_first = bf; rst = 1'b1; lookup_valid = 1'b0; swap_req = 1'b0; flash_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_b_first = bf;
  endtask

  // drive at a negedge, result is registered at the next posedge, sample at the negedge after
  task automatic lookup_check(input string req, input logic [31:0] addr);
    logic [23:0] m;
    logic [1:0] es;
    logic [OFS_W-1:0] eo;
    logic eoor;
    m = addr[23:0];
    eoor = (m >= FLASH);
    if (eoor) begin es = 2'b00; eo = '0; end
    else begin
      es = ((m >= BANK) ^ model_b_first) ? 2'b10 : 2'b01;
      eo = (m >= BANK) ? OFS_W'(m - BANK) : OFS_W'(m);
    end
    lookup_valid = 1'b1; lookup_addr = addr;
    @(negedge clk);
    lookup_valid = 1'b0;
    chk({req, " valid"}, {63'd0, map_valid}, 64'd1);
    chk({req, " sel"}, {62'd0, map_bank_sel}, {62'd0, es});
    chk({req, " ofs"}, {{(64-OFS_W){1'b0}}, map_offset}, {{(64-OFS_W){1'b0}}, eo});
    chk({req, " oor"}, {63'd0, map_oor}, {63'd0, eoor});
  endtask

  task automatic t_reset;
    do_reset(1'b0);
    chk("R1 a_first", {63'd0, a_first}, 64'd1);
    chk("R1 rst_req", {63'd0, core_rst_req}, 64'd0);
    chk("R1 map_valid", {63'd0, map_valid}, 64'd0);
  endtask

  task automatic t_halves;
    lookup_check("R2 low0", 32'h0);
    lookup_check("R2 low", 32'h123);
    lookup_check("R2 lowtop", BANK - 1);
    lookup_check("R3 upbase", BANK);
    lookup_check("R3 uptop", FLASH - 1);
  endtask

  task automatic t_mask_oor;
    lookup_check("R5 mask", 32'hAB000123);
    chk("R5 mask ofs", {{(64-OFS_W){1'b0}}, map_offset}, 64'h123);
    lookup_check("R5 mask upper", 32'hFF000000 | (BANK + 4));
    lookup_check("R6 at size", FLASH);
    lookup_check("R6 max", 32'h00FFFFFF);
    chk("R6 max oor", {63'd0, map_oor}, 64'd1);
  endtask

  task automatic t_latency;
    lookup_valid = 1'b1; lookup_addr = 32'h40;
    @(negedge clk);
    lookup_valid = 1'b0;
    chk("R7 one cycle", {63'd0, map_valid}, 64'd1);
    @(negedge clk);
    chk("R7 idle valid", {63'd0, map_valid}, 64'd0);
    chk("R7 idle sel", {62'd0, map_bank_sel}, 64'd0);
  endtask

  task automatic t_swap_wait;
    int pulses;
    flash_ready = 1'b0; swap_req = 1'b1;
    @(negedge clk);
    swap_req = 1'b0;
    pulses = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (core_rst_req) pulses++;
    end
    chk("R8 no pulse", pulses, 0);
    chk("R8 flag kept", {63'd0, a_first}, {63'd0, ~model_b_first});
    lookup_check("R8 mapping kept", 32'h10);
    flash_ready = 1'b1;
    @(negedge clk);
    model_b_first = ~model_b_first;
    chk("R9 pulse", {63'd0, core_rst_req}, 64'd1);
    chk("R12 a_first flip", {63'd0, a_first}, {63'd0, ~model_b_first});
    @(negedge clk);
    chk("R9 pulse ends", {63'd0, core_rst_req}, 64'd0);
    lookup_check("R4 low to B", 32'h20);
    lookup_check("R4 up to A", BANK + 32'h20);
  endtask

  task automatic t_same_cycle;
    flash_ready = 1'b1; swap_req = 1'b1;
    lookup_valid = 1'b1; lookup_addr = 32'h0;
    @(negedge clk);
    swap_req = 1'b0; lookup_valid = 1'b0;
    chk("R10 old mapping", {62'd0, map_bank_sel}, model_b_first ? 64'd2 : 64'd1);
    model_b_first = ~model_b_first;
    chk("R10 flag flipped", {63'd0, a_first}, {63'd0, ~model_b_first});
    chk("R10 pulse", {63'd0, core_rst_req}, 64'd1);
    lookup_check("R10 new mapping", 32'h0);
  endtask

  task automatic t_dup;
    int pulses;
    flash_ready = 1'b0;
    for (int i = 0; i < 3; i++) begin
      swap_req = 1'b1; @(negedge clk);
      swap_req = 1'b0; @(negedge clk);
    end
    flash_ready = 1'b1;
    pulses = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (core_rst_req) pulses++;
    end
    model_b_first = ~model_b_first;
    chk("R11 one pulse", pulses, 1);
    chk("R11 one flip", {63'd0, a_first}, {63'd0, ~model_b_first});
  endtask

  task automatic t_boot_b;
    do_reset(1'b1);
    chk("R1 boot b a_first", {63'd0, a_first}, 64'd0);
    lookup_check("R4 boot low", 32'h0);
    lookup_check("R4 boot up", BANK);
  endtask

  initial begin
    t_reset();
    t_halves();
    t_mask_oor();
    t_latency();
    t_swap_wait();
    t_same_cycle();
    t_dup();
    t_boot_b();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule